// File: doc/BRIEF.md
# Flash Erase Range Sequencer

This block turns one erase request, given as a byte start address and a byte length, into a series of erase commands for a serial flash device that sits behind a byte-wide SPI shifter. The page size, the page-address shift and the device size in pages are geometry inputs. They are sampled when a request is accepted, so a single build can serve devices with different page layouts. Two serial dividers turn the byte address and the byte length into a page index and a page count. They also confirm that both values are whole pages and that the region fits inside the device.

For each step the sequencer chooses between a single-page erase and an 8-page block erase. The block form is used when the current page index is a multiple of 8 and at least 8 pages are still to be erased. Each command is four bytes, sent under one chip-select window. After each command the block pulses a request to an external status poller and waits until the poller reports that the device is ready. Only then does it start the next command. A one-cycle done pulse closes a good request. A one-cycle error pulse rejects a bad request before any SPI traffic is sent.

Top module: `erase_range_seq`

## Requirements
- R1: A request whose start address or byte length is not a whole multiple of the page size, or whose page size is zero, ends with a one-cycle `err` pulse, no `done` pulse and no byte on the SPI interface.
- R2: A request whose first page index plus page count exceeds `dev_pages` ends with a one-cycle `err` pulse and no SPI traffic. A region that ends exactly at the last page is accepted.
- R3: The opcode byte is 0x50 (block erase) when the current page index is a multiple of 8 and at least 8 pages remain. Otherwise it is 0x81 (page erase).
- R4: Each command is four bytes in this order: opcode, then bits [23:16], [15:8] and [7:0] of the page index shifted left by `page_shift`.
- R5: Chip select (active low on `spi_cs` in the default build) is asserted for exactly the four bytes of one command and released between commands. A byte offered on `spi_tx_data` stays stable until `spi_tx_ack`.
- R6: After the fourth byte of each command, `poll_req` pulses once while chip select is released. No further byte is offered until `poll_rdy` has pulsed.
- R7: After a block erase the current page advances by 8 and the remaining count drops by 8. After a page erase both change by 1. The commands cover the region exactly, with no page repeated or skipped.
- R8: `done` pulses for one cycle after the `poll_rdy` that follows the last command. A zero-length aligned request gives `done` with no SPI traffic.
- R9: `busy` is high from the cycle after a request is accepted until the cycle in which `done` or `err` pulses. A `start` seen while `busy` is high is ignored.
- R10: `page_size`, `page_shift` and `dev_pages` are captured when a request is accepted and apply to the whole request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken when idle |
| start_addr | input | ADDR_W | Region start, in bytes |
| byte_len | input | ADDR_W | Region length, in bytes |
| page_size | input | PS_W | Bytes per page |
| page_shift | input | SH_W | Left shift applied to the page index in the command address |
| dev_pages | input | ADDR_W | Device size, in pages |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | One-cycle pulse when a request is rejected |
| spi_cs | output | 1 | Chip select for the flash |
| spi_tx_valid | output | 1 | Byte offered to the SPI shifter |
| spi_tx_data | output | 8 | Byte to shift out |
| spi_tx_ack | input | 1 | Shifter has taken the offered byte |
| poll_req | output | 1 | Pulse that starts a status poll |
| poll_rdy | input | 1 | Pulse from the poller when the device reports ready |

## Verification
The bench builds the block with its default widths: 24-bit byte addresses, an 11-bit page size and a 4-bit shift, with chip select active low. At run time it drives a 264-byte page with shift 9 and a 64-page device, then switches to a 528-byte page with shift 10. These settings reach page sizes that are not powers of two, so the divider remainder decides alignment. They also reach regions that start off a block boundary and fall into a block erase partway through, regions that end exactly at the top of the device, and regions that overrun it by a few pages. The address bytes come from two different shift amounts. A bench model of the requirements predicts every command byte.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

   localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
   localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
   localparam int         BLK_PAGES      = 8;
   localparam int         BLK_BITS       = 3;
   localparam int         CMD_BYTES      = 4;
   localparam int         CMD_AW         = 24;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIV_ADDR,
      ST_DIV_LEN,
      ST_CHECK,
      ST_ISSUE,
      ST_SEND,
      ST_POLL
   } seq_state_t;

endpackage

// File: rtl/erase_sdiv.sv
// Serial restoring divider: one quotient bit per cycle, N cycles per divide.
module erase_sdiv #(
   parameter int N   = 24,
   parameter int D_W = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [N-1:0]   num,
   input  logic [D_W-1:0] den,
   output logic           fin,
   output logic [N-1:0]   quot,
   output logic [D_W-1:0] rmd
);
   localparam int CW = $clog2(N + 1);

   logic [CW-1:0]  cnt;
   logic           run;
   logic [D_W-1:0] den_q;
   logic [D_W:0]   trial;

   always_comb trial = {rmd, quot[N-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         run   <= 1'b0;
         fin   <= 1'b0;
         quot  <= '0;
         rmd   <= '0;
         den_q <= '0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            quot  <= num;
            rmd   <= '0;
            den_q <= den;
            cnt   <= CW'(N);
            run   <= 1'b1;
         end else if (run) begin
            if (trial >= {1'b0, den_q}) begin
               rmd  <= D_W'(trial - {1'b0, den_q});
               quot <= {quot[N-2:0], 1'b1};
            end else begin
               rmd  <= trial[D_W-1:0];
               quot <= {quot[N-2:0], 1'b0};
            end
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/erase_cmd_tx.sv
// Shifts one four-byte erase command out under a single chip-select window.
module erase_cmd_tx
   import erase_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [7:0]        opcode,
   input  logic [CMD_AW-1:0] addr,
   output logic              cs_act,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_ack,
   output logic              fin
);
   logic [7:0]        op_q;
   logic [CMD_AW-1:0] addr_q;
   logic [1:0]        idx;

   always_comb begin
      case (idx)
         2'd0:    tx_data = op_q;
         2'd1:    tx_data = addr_q[23:16];
         2'd2:    tx_data = addr_q[15:8];
         default: tx_data = addr_q[7:0];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q     <= '0;
         addr_q   <= '0;
         idx      <= '0;
         cs_act   <= 1'b0;
         tx_valid <= 1'b0;
         fin      <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (launch) begin
            op_q     <= opcode;
            addr_q   <= addr;
            idx      <= '0;
            cs_act   <= 1'b1;
            tx_valid <= 1'b1;
         end else if (tx_valid && tx_ack) begin
            if (idx == 2'(CMD_BYTES - 1)) begin
               tx_valid <= 1'b0;
               cs_act   <= 1'b0;
               fin      <= 1'b1;
            end else begin
               idx <= idx + 2'd1;
            end
         end
      end
   end
endmodule

// File: rtl/erase_range_seq.sv
module erase_range_seq
   import erase_seq_pkg::*;
#(
   parameter int ADDR_W        = 24,
   parameter int PS_W          = 11,
   parameter int SH_W          = 4,
   parameter bit CS_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] byte_len,
   input  logic [PS_W-1:0]   page_size,
   input  logic [SH_W-1:0]   page_shift,
   input  logic [ADDR_W-1:0] dev_pages,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              spi_cs,
   output logic              spi_tx_valid,
   output logic [7:0]        spi_tx_data,
   input  logic              spi_tx_ack,
   output logic              poll_req,
   input  logic              poll_rdy
);
   localparam int WIDE = ADDR_W + (1 << SH_W);

   if (ADDR_W < 12 || ADDR_W > 32) begin : g_bad_addr_w
      $error("erase_range_seq: ADDR_W must lie in 12..32");
   end
   if (PS_W < 4 || PS_W >= ADDR_W) begin : g_bad_ps_w
      $error("erase_range_seq: PS_W must lie in 4..ADDR_W-1");
   end
   if (WIDE < CMD_AW) begin : g_bad_sh_w
      $error("erase_range_seq: shifted page address narrower than command address");
   end

   seq_state_t        state;
   logic [ADDR_W-1:0] len_q;
   logic [PS_W-1:0]   ps_q;
   logic [SH_W-1:0]   sh_q;
   logic [ADDR_W-1:0] pages_q;
   logic [ADDR_W-1:0] cur_pg;
   logic [ADDR_W-1:0] left_pg;
   logic              rem_a_bad;
   logic              rem_l_bad;
   logic              use_blk;

   logic              div_go;
   logic [ADDR_W-1:0] div_num;
   logic [PS_W-1:0]   div_den;
   logic              div_fin;
   logic [ADDR_W-1:0] div_quot;
   logic [PS_W-1:0]   div_rmd;

   logic              tx_launch;
   logic              tx_fin;
   logic              cs_act;
   logic              blk_ok;
   logic              req_bad;
   logic [7:0]        cmd_op;
   logic [CMD_AW-1:0] cmd_addr;
   logic [ADDR_W-1:0] stride;

   // Dividers share one serial unit: first the address, then the length.
   always_comb begin
      div_go  = (state == ST_IDLE && start) || (state == ST_DIV_ADDR && div_fin);
      div_num = (state == ST_IDLE) ? start_addr : len_q;
      div_den = (state == ST_IDLE) ? page_size  : ps_q;
   end

   erase_sdiv #(.N(ADDR_W), .D_W(PS_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .num   (div_num),
      .den   (div_den),
      .fin   (div_fin),
      .quot  (div_quot),
      .rmd   (div_rmd)
   );

   always_comb begin
      blk_ok    = (cur_pg[BLK_BITS-1:0] == '0) && (left_pg >= ADDR_W'(BLK_PAGES));
      cmd_op    = blk_ok ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
      cmd_addr  = CMD_AW'(WIDE'(cur_pg) << sh_q);
      stride    = use_blk ? ADDR_W'(BLK_PAGES) : ADDR_W'(1);
      req_bad   = (ps_q == '0) || rem_a_bad || rem_l_bad ||
                  (({1'b0, cur_pg} + {1'b0, left_pg}) > {1'b0, pages_q});
      tx_launch = (state == ST_ISSUE);
      busy      = (state != ST_IDLE);
   end

   erase_cmd_tx u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (tx_launch),
      .opcode   (cmd_op),
      .addr     (cmd_addr),
      .cs_act   (cs_act),
      .tx_valid (spi_tx_valid),
      .tx_data  (spi_tx_data),
      .tx_ack   (spi_tx_ack),
      .fin      (tx_fin)
   );

   if (CS_ACTIVE_LOW) begin : g_cs_low
      assign spi_cs = ~cs_act;
   end else begin : g_cs_high
      assign spi_cs = cs_act;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         len_q     <= '0;
         ps_q      <= '0;
         sh_q      <= '0;
         pages_q   <= '0;
         cur_pg    <= '0;
         left_pg   <= '0;
         rem_a_bad <= 1'b0;
         rem_l_bad <= 1'b0;
         use_blk   <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
         poll_req  <= 1'b0;
      end else begin
         done     <= 1'b0;
         err      <= 1'b0;
         poll_req <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  len_q   <= byte_len;
                  ps_q    <= page_size;
                  sh_q    <= page_shift;
                  pages_q <= dev_pages;
                  state   <= ST_DIV_ADDR;
               end
            end
            ST_DIV_ADDR: begin
               if (div_fin) begin
                  cur_pg    <= div_quot;
                  rem_a_bad <= |div_rmd;
                  state     <= ST_DIV_LEN;
               end
            end
            ST_DIV_LEN: begin
               if (div_fin) begin
                  left_pg   <= div_quot;
                  rem_l_bad <= |div_rmd;
                  state     <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (req_bad) begin
                  err   <= 1'b1;
                  state <= ST_IDLE;
               end else if (left_pg == '0) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  state <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               use_blk <= blk_ok;
               state   <= ST_SEND;
            end
            ST_SEND: begin
               if (tx_fin) begin
                  poll_req <= 1'b1;
                  state    <= ST_POLL;
               end
            end
            ST_POLL: begin
               if (poll_rdy) begin
                  cur_pg  <= cur_pg + stride;
                  left_pg <= left_pg - stride;
                  if (left_pg == stride) begin
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     state <= ST_ISSUE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/erase_range_seq_chk.sv
module erase_range_seq_chk #(
   parameter bit CS_ACTIVE_LOW = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic       err,
   input logic       spi_cs,
   input logic       spi_tx_valid,
   input logic [7:0] spi_tx_data,
   input logic       spi_tx_ack,
   input logic       poll_req,
   input logic       poll_rdy
);
   logic       cs_act;
   logic [2:0] byte_cnt;
   logic       poll_pend;

   assign cs_act = CS_ACTIVE_LOW ? ~spi_cs : spi_cs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt  <= '0;
         poll_pend <= 1'b0;
      end else begin
         if (!cs_act)                        byte_cnt <= '0;
         else if (spi_tx_valid && spi_tx_ack) byte_cnt <= byte_cnt + 3'd1;
         if (poll_req)      poll_pend <= 1'b1;
         else if (poll_rdy) poll_pend <= 1'b0;
      end
   end

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r1_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));
   a_r9_end_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> $past(busy));
   a_r5_valid_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
      spi_tx_valid |-> cs_act);
   a_r5_four_bytes: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_act) |-> (byte_cnt == 3'd4));
   a_r5_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_tx_valid && !spi_tx_ack) |=> (spi_tx_valid && $stable(spi_tx_data)));
   a_r6_quiet_while_polling: assert property (@(posedge clk) disable iff (!rst_n)
      poll_pend |-> !spi_tx_valid);
   a_r6_poll_outside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      poll_req |-> !cs_act);
endmodule

bind erase_range_seq erase_range_seq_chk #(.CS_ACTIVE_LOW(CS_ACTIVE_LOW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .done         (done),
   .err          (err),
   .spi_cs       (spi_cs),
   .spi_tx_valid (spi_tx_valid),
   .spi_tx_data  (spi_tx_data),
   .spi_tx_ack   (spi_tx_ack),
   .poll_req     (poll_req),
   .poll_rdy     (poll_rdy)
);

// File: tb/erase_range_seq_bench.sv
module erase_range_seq_bench;
   localparam int PAGES = 64;
   localparam int NV    = 10;
   // Stimulus table: start address and length in bytes, 264-byte pages, shift 9.
   localparam logic [31:0] VA [NV] = '{32'd0,     32'd792,  32'd1320, 32'd2112, 32'd14784,
                                      32'd15840, 32'd100,  32'd0,    32'd16632, 32'd0};
   localparam logic [31:0] VL [NV] = '{32'd4224,  32'd528,  32'd3168, 32'd1848, 32'd2112,
                                      32'd2112,  32'd264,  32'd100,  32'd264,   32'd0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] start_addr = '0;
   logic [23:0] byte_len = '0;
   logic [10:0] page_size = 11'd264;
   logic [3:0]  page_shift = 4'd9;
   logic [23:0] dev_pages = 24'(PAGES);
   logic        busy, done, err, spi_cs, spi_tx_valid, poll_req;
   logic [7:0]  spi_tx_data;
   logic        spi_tx_ack = 1'b0;
   logic        poll_rdy = 1'b0;

   int n_chk = 0, n_fail = 0;
   int n_done = 0, n_err = 0, ncap = 0, cs_bad = 0, ovl_bad = 0, win_cnt = 0;
   logic [7:0] cap [0:1023];
   logic [7:0] expb [0:1023];
   bit  poll_pend = 1'b0;
   int  pdelay = 0;
   bit  cs_prev = 1'b0;

   always #2 clk = ~clk;

   erase_range_seq u_erase_range_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .byte_len(byte_len), .page_size(page_size), .page_shift(page_shift),
      .dev_pages(dev_pages), .busy(busy), .done(done), .err(err),
      .spi_cs(spi_cs), .spi_tx_valid(spi_tx_valid), .spi_tx_data(spi_tx_data),
      .spi_tx_ack(spi_tx_ack), .poll_req(poll_req), .poll_rdy(poll_rdy));

   // SPI shifter, status poller and pulse monitor, all at the falling edge.
   always @(negedge clk) begin
      if (done) n_done++;
      if (err)  n_err++;
      if (spi_tx_valid && !spi_tx_ack) begin
         spi_tx_ack = 1'b1;
         cap[ncap % 1024] = spi_tx_data;
         ncap++;
         if (spi_cs) cs_bad++;
         else win_cnt++;
         if (poll_pend) ovl_bad++;
      end else begin
         spi_tx_ack = 1'b0;
      end
      if (cs_prev && spi_cs) begin
         if (win_cnt != 4) cs_bad++;
         win_cnt = 0;
      end
      cs_prev = !spi_cs;
      poll_rdy = 1'b0;
      if (poll_req) begin
         poll_pend = 1'b1;
         pdelay = 3;
      end else if (poll_pend) begin
         if (pdelay == 0) begin
            poll_rdy = 1'b1;
            poll_pend = 1'b0;
         end else pdelay--;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // Model of the requirements: fills expb, returns error flag and byte count.
   task automatic model(input int a, input int l, input int ps, input int sh, input int pg_total,
                        output bit e_err, output int e_nb);
      int pg, left, ad;
      bit blk;
      e_nb = 0;
      e_err = (ps == 0) || (a % ps != 0) || (l % ps != 0) || (a / ps + l / ps > pg_total);
      if (e_err) return;
      pg = a / ps;
      left = l / ps;
      while (left > 0) begin
         blk = (pg % 8 == 0) && (left >= 8);
         ad = pg << sh;
         expb[e_nb]   = blk ? 8'h50 : 8'h81;
         expb[e_nb+1] = 8'((ad >> 16) & 255);
         expb[e_nb+2] = 8'((ad >> 8) & 255);
         expb[e_nb+3] = 8'(ad & 255);
         e_nb += 4;
         pg += blk ? 8 : 1;
         left -= blk ? 8 : 1;
      end
   endtask

   task automatic run_req(input int a, input int l, input int ps, input int sh,
                          input int poke_at, input string tag);
      bit e_err;
      int e_nb, b_done, b_err, b_cap, b_cs, b_ovl, mism;
      bit finished;
      model(a, l, ps, sh, PAGES, e_err, e_nb);
      b_done = n_done; b_err = n_err; b_cap = ncap; b_cs = cs_bad; b_ovl = ovl_bad;
      @(negedge clk);
      start_addr = 24'(a); byte_len = 24'(l);
      page_size = 11'(ps); page_shift = 4'(sh);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R10: scramble geometry after acceptance; the design must ignore it
      page_size = 11'd5; page_shift = 4'd1; dev_pages = 24'd1;
      finished = 1'b0;
      for (int c = 0; c < 8000 && !finished; c++) begin
         @(negedge clk);
         if (poke_at > 0 && c == poke_at) begin
            chk(busy == 1'b1, "R9", {tag, " busy mid-request"}, busy, 1);
            start_addr = 24'd264; byte_len = 24'd264; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
         if (n_done + n_err > b_done + b_err) finished = 1'b1;
      end
      chk(finished, "R8", {tag, " request ended"}, finished, 1);
      repeat (12) @(negedge clk);
      dev_pages = 24'(PAGES);
      chk(n_err - b_err == int'(e_err), e_err ? "R1/R2" : "R1", {tag, " err pulses"},
          n_err - b_err, int'(e_err));
      chk(n_done - b_done == int'(!e_err), "R8", {tag, " done pulses"},
          n_done - b_done, int'(!e_err));
      chk(ncap - b_cap == e_nb, "R7", {tag, " command byte count"}, ncap - b_cap, e_nb);
      mism = 0;
      for (int i = 0; i < e_nb && i < ncap - b_cap; i++)
         if (cap[(b_cap + i) % 1024] != expb[i]) mism++;
      chk(mism == 0, "R3/R4", {tag, " mismatched command bytes"}, mism, 0);
      chk(cs_bad == b_cs, "R5", {tag, " chip-select window faults"}, cs_bad - b_cs, 0);
      chk(ovl_bad == b_ovl, "R6", {tag, " bytes sent during poll"}, ovl_bad - b_ovl, 0);
      chk(busy == 1'b0, "R9", {tag, " busy after end"}, busy, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual expired expected finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state, R5 R6 R8 R9
      chk(busy == 1'b0, "R9", "busy in reset", busy, 0);
      chk(spi_cs == 1'b1 && spi_tx_valid == 1'b0, "R5", "cs idle in reset", spi_cs, 1);
      chk(done == 1'b0 && err == 1'b0, "R8", "no pulses in reset", done, 0);
      chk(poll_req == 1'b0, "R6", "no poll in reset", poll_req, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy == 1'b0 && spi_cs == 1'b1, "R9", "idle after reset", busy, 0);

      for (int v = 0; v < NV; v++)
         run_req(int'(VA[v]), int'(VL[v]), 264, 9, 0, $sformatf("vec%0d", v));

      // R10: different geometry, block erase at page 8 with 528-byte pages, shift 10
      run_req(4224, 4224, 528, 10, 0, "geom528");
      // R10: larger page count with shift 10 mixing pages and a block
      run_req(528 * 6, 528 * 11, 528, 10, 0, "geom528mix");
      // R1: zero page size is rejected
      run_req(0, 0, 0, 9, 0, "pszero");
      // R9: start during a running request is ignored
      run_req(0, 4224, 264, 9, 60, "poke");
      // R2: region ending exactly at the last page, whole device
      run_req(0, 264 * PAGES, 264, 9, 0, "fulldev");

      summary();
      $finish;
   end
endmodule